// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is one switching node of a two-dimensional mesh network. It has five links: one toward each of its four neighbours (East, West, North, South) and one toward the processing element attached to it (Local). Data moves in 8-bit flits, each link carrying a valid/ready pair in each direction. Every packet opens with two header flits: the first gives the target column and row, and the second gives how many payload flits follow.

Each input link feeds a small flit queue. When a header reaches the head of a queue, the input works out an output port by dimension-ordered routing. It corrects the column first, then the row, and delivers to Local once both coordinates match. The input then bids for that output. Every output has its own round-robin arbiter. A winning input keeps the output until the last payload flit has left, which it finds by counting down the length from the second header flit. A flit moves whenever the receiver can take that single flit, so a long packet can span several routers. A blocked packet waits in place, and the stall spreads backward through ready.

The node's own column and row, the flit width and the queue depth are parameters.

Top module: `wxy_mesh_router`

## Requirements
- R1: After reset every out_valid bit is 0 and every in_ready bit is 1.
- R2: A packet is 2+L flits long. Flit 0 carries the target column in bits [7:4] and the target row in bits [3:0]. Flit 1 carries the payload count L. All 2+L flits leave on one output, unchanged and in their arrival order.
- R3: Port indices are 0 Local, 1 East (larger column), 2 West (smaller column), 3 North (larger row) and 4 South (smaller row). A target column above the node's own goes East and one below goes West. When the column matches, a target row above goes North and one below goes South. When both match, the packet goes Local. The column is always resolved before the row.
- R4: A packet with L = 0 is exactly two flits long and frees its output after the second flit.
- R5: A packet longer than the input queue passes completely. Each flit needs only its own ready to move on.
- R6: Once an output has started a packet, it carries no flit of any other packet until that packet's last flit has left.
- R7: Each output grants waiting inputs in round-robin order. The search starts at the index after the last winner (index 0 after reset), and the lowest requesting index at or after that point wins.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged. An input drops in_ready once its queue holds FIFO_DEPTH flits. No flit is lost or duplicated.
- R9: Packets bound for different outputs move in the same cycles without waiting for one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Flit offered on each input link, bit index = port index |
| in_data | input | 5*FLIT_W | Input flits, port p at bits [p*FLIT_W +: FLIT_W] |
| in_ready | output | 5 | Input queue can take a flit |
| out_valid | output | 5 | Flit offered on each output link |
| out_data | output | 5*FLIT_W | Output flits, port p at bits [p*FLIT_W +: FLIT_W] |
| out_ready | input | 5 | Downstream can take a flit |

## Verification
The bench places the node at column 1, row 1. From there each of the four neighbour directions and Local can be reached, and a target that differs in both coordinates shows whether the column is resolved first. The queue depth is set to 3, which is not a power of two. This exercises the pointer wrap of the ring queue, and a 20-payload packet is then several times deeper than any queue. Three inputs contending for North give a fixed, predictable grant order under equal arrival. A held-off North link fills a queue and so shows both the stall and the loss of in_ready.

// File: rtl/wxy_pkg.sv
package wxy_pkg;
   localparam int NPORT = 5;
   localparam int PW    = 3;

   typedef enum logic [PW-1:0] {
      PT_LOCAL = 3'd0,
      PT_EAST  = 3'd1,
      PT_WEST  = 3'd2,
      PT_NORTH = 3'd3,
      PT_SOUTH = 3'd4
   } port_e;

   typedef enum logic [1:0] {
      PS_HEAD = 2'd0,
      PS_LEN  = 2'd1,
      PS_BODY = 2'd2
   } pkt_st_e;
endpackage

// File: rtl/wxy_flit_fifo.sv
module wxy_flit_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         not_empty,
   output logic         not_full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("wxy_flit_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic         full_q;
         logic [W-1:0] data_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               full_q <= 1'b0;
            end else if (push) begin
               full_q <= 1'b1;
            end else if (pop) begin
               full_q <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (push) data_q <= din;
         end

         assign dout      = data_q;
         assign not_empty = full_q;
         assign not_full  = !full_q;
      end else begin : g_ring
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] wr_q, rd_q;
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
               if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
               case ({push, pop})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (push) mem[wr_q] <= din;
         end

         assign dout      = mem[rd_q];
         assign not_empty = (cnt_q != '0);
         assign not_full  = (cnt_q != CW'(DEPTH));

         // R8
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CW'(DEPTH)) && !pop |=> (cnt_q == CW'(DEPTH)) && $stable(wr_q));
      end
   endgenerate
endmodule

// File: rtl/wxy_in_ctrl.sv
module wxy_in_ctrl
   import wxy_pkg::*;
#(
   parameter int FLIT_W = 8,
   parameter int MY_X   = 0,
   parameter int MY_Y   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLIT_W-1:0] head,
   input  logic              not_empty,
   input  logic              gnt,
   input  logic              dst_ready,
   output port_e             cur_dest,
   output logic              req,
   output logic              pop,
   output logic              rel
);
   localparam int CW = FLIT_W / 2;

   pkt_st_e           st_q;
   port_e             dest_q;
   port_e             route_now;
   logic [FLIT_W-1:0] cnt_q;
   logic [CW-1:0]     tgt_x, tgt_y;

   assign tgt_x = head[FLIT_W-1:CW];
   assign tgt_y = head[CW-1:0];

   always_comb begin
      if (tgt_x > CW'(MY_X))      route_now = PT_EAST;
      else if (tgt_x < CW'(MY_X)) route_now = PT_WEST;
      else if (tgt_y > CW'(MY_Y)) route_now = PT_NORTH;
      else if (tgt_y < CW'(MY_Y)) route_now = PT_SOUTH;
      else                        route_now = PT_LOCAL;
   end

   assign cur_dest = (st_q == PS_HEAD) ? route_now : dest_q;
   assign req      = (st_q != PS_HEAD) || not_empty;
   assign pop      = not_empty && gnt && dst_ready;
   assign rel      = pop && (((st_q == PS_LEN) && (head == '0)) ||
                             ((st_q == PS_BODY) && (cnt_q == FLIT_W'(1))));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= PS_HEAD;
         dest_q <= PT_LOCAL;
         cnt_q  <= '0;
      end else if (pop) begin
         case (st_q)
            PS_HEAD: begin
               st_q   <= PS_LEN;
               dest_q <= route_now;
            end
            PS_LEN: begin
               cnt_q <= head;
               st_q  <= (head == '0) ? PS_HEAD : PS_BODY;
            end
            default: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == FLIT_W'(1)) st_q <= PS_HEAD;
            end
         endcase
      end
   end

   // R4
   release_to_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel |=> (st_q == PS_HEAD));

   // R2
   len_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_BODY) && pop && (cnt_q != FLIT_W'(1))
      |=> (st_q == PS_BODY) && (cnt_q == $past(cnt_q) - 1'b1));

   // R3
   dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != PS_HEAD) && !rel |=> $stable(dest_q));
endmodule

// File: rtl/wxy_rr_arb.sv
module wxy_rr_arb #(
   parameter int N = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   input  logic                 rel,
   output logic                 locked,
   output logic [$clog2(N)-1:0] owner
);
   localparam int IW = $clog2(N);

   logic [IW-1:0] ptr_q, pick;
   logic          any;

   always_comb begin
      int idx;
      any  = 1'b0;
      pick = '0;
      for (int k = 0; k < N; k++) begin
         idx = int'(ptr_q) + k;
         if (idx >= N) idx = idx - N;
         if (!any && req[idx]) begin
            any  = 1'b1;
            pick = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked <= 1'b0;
         owner  <= '0;
         ptr_q  <= '0;
      end else if (!locked) begin
         if (any) begin
            locked <= 1'b1;
            owner  <= pick;
            ptr_q  <= (pick == IW'(N - 1)) ? '0 : pick + 1'b1;
         end
      end else if (rel) begin
         locked <= 1'b0;
      end
   end

   // R6
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked && !rel |=> locked && $stable(owner));

   // R7
   grant_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked && (req != '0) |=> locked);
endmodule

// File: rtl/wxy_mesh_router.sv
module wxy_mesh_router
   import wxy_pkg::*;
#(
   parameter int FLIT_W     = 8,
   parameter int FIFO_DEPTH = 4,
   parameter int MY_X       = 0,
   parameter int MY_Y       = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NPORT-1:0]          in_valid,
   input  logic [NPORT*FLIT_W-1:0]   in_data,
   output logic [NPORT-1:0]          in_ready,
   output logic [NPORT-1:0]          out_valid,
   output logic [NPORT*FLIT_W-1:0]   out_data,
   input  logic [NPORT-1:0]          out_ready
);
   localparam int CW = FLIT_W / 2;

   generate
      if ((FLIT_W < 2) || (FLIT_W % 2 != 0)) begin : g_bad_width
         $error("wxy_mesh_router: FLIT_W must be even and at least 2");
      end
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("wxy_mesh_router: FIFO_DEPTH must be at least 1");
      end
      if ((MY_X < 0) || (MY_X >= (1 << CW)) || (MY_Y < 0) || (MY_Y >= (1 << CW))) begin : g_bad_xy
         $error("wxy_mesh_router: node coordinates do not fit the header field");
      end
   endgenerate

   logic [FLIT_W-1:0] head     [NPORT];
   logic [NPORT-1:0]  ne, req, pop, rel, gnt, dst_rdy;
   port_e             cur_dest [NPORT];
   logic [NPORT-1:0]  lock, orel;
   logic [PW-1:0]     owner    [NPORT];
   logic [NPORT-1:0]  req_col  [NPORT];
   logic [NPORT-1:0]  gnt_row  [NPORT];

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_in
         logic push;
         assign push = in_valid[i] && in_ready[i];

         wxy_flit_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .din       (in_data[i*FLIT_W +: FLIT_W]),
            .pop       (pop[i]),
            .dout      (head[i]),
            .not_empty (ne[i]),
            .not_full  (in_ready[i])
         );

         wxy_in_ctrl #(.FLIT_W(FLIT_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .head      (head[i]),
            .not_empty (ne[i]),
            .gnt       (gnt[i]),
            .dst_ready (dst_rdy[i]),
            .cur_dest  (cur_dest[i]),
            .req       (req[i]),
            .pop       (pop[i]),
            .rel       (rel[i])
         );
      end

      for (genvar o = 0; o < NPORT; o++) begin : g_out
         wxy_rr_arb #(.N(NPORT)) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_col[o]),
            .rel    (orel[o]),
            .locked (lock[o]),
            .owner  (owner[o])
         );

         assign out_valid[o]                 = lock[o] && ne[owner[o]];
         assign out_data[o*FLIT_W +: FLIT_W] = head[owner[o]];
         assign orel[o]                      = lock[o] && rel[owner[o]];

         // R8
         stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o]
            |=> out_valid[o] && $stable(out_data[o*FLIT_W +: FLIT_W]));

         // R6
         one_feeder_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(req_col[o] & gnt));
      end
   endgenerate

   always_comb begin
      for (int o = 0; o < NPORT; o++) begin
         for (int i = 0; i < NPORT; i++) begin
            req_col[o][i] = req[i] && (int'(cur_dest[i]) == o);
            gnt_row[i][o] = lock[o] && (int'(owner[o]) == i);
         end
      end
      for (int i = 0; i < NPORT; i++) begin
         gnt[i]     = gnt_row[i][cur_dest[i]];
         dst_rdy[i] = out_ready[cur_dest[i]];
      end
   end

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_chk
         // R6
         single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_row[i]));
      end
   endgenerate
endmodule

// File: tb/wxy_mesh_router_bench.sv
module wxy_mesh_router_bench;
   localparam int NP = 5;
   localparam int FW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] in_valid = '0;
   logic [NP*FW-1:0] in_data = '0;
   logic [NP-1:0] in_ready;
   logic [NP-1:0] out_valid;
   logic [NP*FW-1:0] out_data;
   logic [NP-1:0] out_ready = '1;

   always #2.5 clk = ~clk;

   wxy_mesh_router #(.FLIT_W(FW), .FIFO_DEPTH(3), .MY_X(1), .MY_Y(1)) u_wxy_mesh_router (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready)
   );

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;
   bit timed_out = 0;

   logic [7:0] drv [NP][$];
   logic [7:0] expq [NP][NP][$];
   int         order_north [$];

   bit         acc_in [NP];
   bit         fire_out [NP];
   logic [7:0] fire_dat [NP];

   bit         pend [NP];
   logic [7:0] h0 [NP];
   int         cur_src [NP];
   int         remain [NP];
   bit         concurrent_seen = 0;

   function automatic int route(input int tx, input int ty);
      if (tx > 1) return 1;
      if (tx < 1) return 2;
      if (ty > 1) return 3;
      if (ty < 1) return 4;
      return 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input int src, input int tx, input int ty, input int len, input int tag);
      logic [7:0] f;
      int d;
      d = route(tx, ty);
      f = {tx[3:0], ty[3:0]};
      drv[src].push_back(f); expq[src][d].push_back(f);
      f = len[7:0];
      drv[src].push_back(f); expq[src][d].push_back(f);
      for (int k = 0; k < len; k++) begin
         f = 8'((tag << 4) + k);
         drv[src].push_back(f); expq[src][d].push_back(f);
      end
   endtask

   initial begin
      for (int o = 0; o < NP; o++) begin
         cur_src[o] = -1; pend[o] = 0; remain[o] = 0;
      end
   end

   initial forever begin
      @(posedge clk);
      cycles++;
      for (int s = 0; s < NP; s++) begin
         acc_in[s]   = in_valid[s] && in_ready[s];
         fire_out[s] = out_valid[s] && out_ready[s];
         fire_dat[s] = out_data[s*FW +: FW];
      end
   end

   initial forever begin
      int nf;
      @(negedge clk);
      nf = 0;
      for (int s = 0; s < NP; s++) begin
         if (acc_in[s] && drv[s].size() > 0) void'(drv[s].pop_front());
         acc_in[s] = 0;
      end
      for (int o = 0; o < NP; o++) begin
         if (fire_out[o]) begin
            nf++;
            fire_out[o] = 0;
            model_out(o, fire_dat[o]);
         end
      end
      if (nf >= 2) concurrent_seen = 1;
      for (int s = 0; s < NP; s++) begin
         in_valid[s] = rst_n && (drv[s].size() > 0);
         in_data[s*FW +: FW] = (drv[s].size() > 0) ? drv[s][0] : 8'h00;
      end
   end

   task automatic model_out(input int o, input logic [7:0] d);
      int found;
      if (cur_src[o] < 0 && !pend[o]) begin
         found = -1;
         for (int s = 0; s < NP; s++)
            if (found < 0 && expq[s][o].size() >= 2 && expq[s][o][0] == d) found = s;
         // R3: a header may only appear on the output its target selects
         check(found >= 0, "R3", int'(d), -1);
         pend[o] = 1; h0[o] = d;
      end else if (pend[o]) begin
         found = -1;
         for (int s = 0; s < NP; s++)
            if (found < 0 && expq[s][o].size() >= 2 && expq[s][o][0] == h0[o] && expq[s][o][1] == d)
               found = s;
         // R2: second header flit carries the payload count
         check(found >= 0, "R2", int'(d), -1);
         pend[o] = 0;
         if (found >= 0) begin
            void'(expq[found][o].pop_front());
            void'(expq[found][o].pop_front());
            if (o == 3) order_north.push_back(found);
            if (d != 0) begin cur_src[o] = found; remain[o] = int'(d); end
         end
      end else begin
         // R6: payload must come contiguously from the owning packet
         check(expq[cur_src[o]][o].size() > 0 && expq[cur_src[o]][o][0] == d, "R6", int'(d),
               (expq[cur_src[o]][o].size() > 0) ? int'(expq[cur_src[o]][o][0]) : -1);
         if (expq[cur_src[o]][o].size() > 0) void'(expq[cur_src[o]][o].pop_front());
         remain[o]--;
         if (remain[o] == 0) cur_src[o] = -1;
      end
   endtask

   function automatic int left_over();
      int n = 0;
      for (int s = 0; s < NP; s++) begin
         n += drv[s].size();
         for (int o = 0; o < NP; o++) n += expq[s][o].size();
      end
      return n;
   endfunction

   task automatic drain(input string req);
      int w = 0;
      while (left_over() != 0 && w < 3000) begin @(negedge clk); w++; end
      repeat (4) @(negedge clk);
      // no flit lost, duplicated or stuck
      check(left_over() == 0, req, left_over(), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int p = 0; p < NP; p++) begin
         check(out_valid[p] == 1'b0, "R1", int'(out_valid[p]), 0);
         check(in_ready[p] == 1'b1, "R1", int'(in_ready[p]), 1);
      end

      // R3: each direction, and column resolved before row
      send(0, 2, 1, 2, 1);
      send(0, 0, 1, 1, 2);
      send(0, 1, 2, 3, 3);
      send(0, 1, 0, 2, 4);
      send(0, 1, 1, 1, 5);
      send(0, 2, 3, 2, 6);
      send(0, 0, 0, 1, 7);
      drain("R3");

      // R4: zero-length packets back to back on one output
      send(1, 0, 1, 0, 1);
      send(1, 0, 1, 0, 2);
      send(1, 0, 1, 1, 3);
      drain("R4");

      // R5: packet far deeper than the queue
      send(4, 0, 3, 20, 9);
      drain("R5");

      // R9: disjoint outputs at once
      send(1, 0, 1, 6, 1);
      send(2, 2, 1, 6, 2);
      send(3, 1, 0, 6, 3);
      send(4, 1, 2, 6, 4);
      send(0, 1, 1, 6, 5);
      drain("R9");
      check(concurrent_seen, "R9", int'(concurrent_seen), 1);

      // R7: three inputs, two packets each, all to North
      order_north.delete();
      send(0, 1, 2, 1, 1); send(0, 1, 2, 1, 4);
      send(1, 1, 2, 2, 2); send(1, 1, 2, 2, 5);
      send(2, 1, 2, 3, 3); send(2, 1, 2, 3, 6);
      drain("R7");
      check(order_north.size() == 6, "R7", order_north.size(), 6);
      for (int k = 0; k < 6 && k < order_north.size(); k++)
         check(order_north[k] == (k % 3), "R7", order_north[k], k % 3);

      // R8: stalled output holds its flit; input queue fills
      out_ready[3] = 1'b0;
      send(0, 1, 2, 8, 7);
      repeat (20) @(negedge clk);
      check(out_valid[3] == 1'b1, "R8", int'(out_valid[3]), 1);
      check(out_data[3*FW +: FW] == 8'h12, "R8", int'(out_data[3*FW +: FW]), 8'h12);
      check(in_ready[0] == 1'b0, "R8", int'(in_ready[0]), 0);
      repeat (3) @(negedge clk);
      check(out_data[3*FW +: FW] == 8'h12, "R8", int'(out_data[3*FW +: FW]), 8'h12);
      out_ready[3] = 1'b1;
      drain("R8");

      // R1/R8: idle again afterwards
      check(out_valid == '0, "R1", int'(out_valid), 0);
      check(in_ready == '1, "R8", int'(in_ready), 31);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      wait (cycles >= 150000);
      timed_out = 1;
      check(1'b0, "watchdog", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule